// File: doc/BRIEF.md
# Supply Monitor Control Register

This block is the digital side of a supply voltage monitor. It sits behind one 16-bit peripheral register on a CPU register bus. Software uses the register to set a 4-bit trip code, switch the monitor on, choose whether it keeps running while the CPU is stopped, and enable its interrupt. The trip code goes unchanged to an analog comparator. Each code step raises the trip point by 0.2 V, starting at 2.3 V for code 0. The comparator returns a one-bit "supply below threshold" level, and that level is synchronised inside the block before any logic uses it.

After the comparator is switched on, the block counts a fixed power-up delay before it reports ready. It then latches a sticky low-supply flag whenever the synchronised comparator level is high. The interrupt request is that flag gated by the interrupt enable. Stop mode switches the comparator off unless stop-mode monitoring was requested, and the power-up delay then runs again.

Top module: `supmon_ctrl`

## Requirements
- R1: The read value places the trip code in bits 11:8, stop-mode monitoring in bit 4, the low-supply flag in bit 3, the interrupt enable in bit 2, ready in bit 1 and the monitor enable in bit 0. Bits 15:12 and 7:5 always read 0.
- R2: After reset every register bit is 0, `thr_code` is 0 and `cmp_en` and `irq` are low.
- R3: A write loads bits 11:8 into the trip code only if the monitor enable is 0 before that write. Otherwise the code is unchanged. `thr_code` always equals the stored code.
- R4: Every write loads bits 0, 2 and 4 into the monitor enable, the interrupt enable and stop-mode monitoring.
- R5: Ready is read-only. It rises exactly `PWRUP_CYCLES` clock edges after `cmp_en` goes high, and it reads 0 whenever `cmp_en` is low.
- R6: `cmp_en` is high exactly when the monitor enable is 1 and not (`stop_mode` is 1 and stop-mode monitoring is 0).
- R7: `below_raw` passes through a two-flop synchroniser. When the synchronised level is 1 while ready is 1, the flag is set at the next edge. The flag then stays set until software writes bit 3 as 0.
- R8: When a write of 0 to bit 3 falls in the same cycle as a hardware set, the flag ends up 1.
- R9: A write with bit 3 = 1 sets the flag. `irq` equals the flag ANDed with the interrupt enable.
- R10: In stop mode with stop-mode monitoring at 0, ready drops at once. When stop mode ends, the full power-up delay runs again. With stop-mode monitoring at 1, ready is not disturbed by stop mode.
- R11: Clearing the monitor enable drops ready and restarts the delay. It does not change the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Register read value |
| stop_mode | input | 1 | CPU is in stop mode |
| below_raw | input | 1 | Asynchronous comparator output, 1 = supply below trip point |
| thr_code | output | 4 | Trip code to the comparator |
| cmp_en | output | 1 | Comparator power enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardware set of the low-supply flag and a software write of 0 to that flag can land in the same clock. The bench holds `below_raw` high while the monitor is ready, then issues a clearing write. It checks that the flag is still 1 after that edge and that `irq` never drops. A second collision is a write that tries to change the trip code in the cycle after the enable was set. That write must be discarded, and the reference model compares the code on every clock.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int REG_W    = 16;
  localparam int THR_W    = 4;
  localparam int B_EN     = 0;
  localparam int B_RDY    = 1;
  localparam int B_IE     = 2;
  localparam int B_FLAG   = 3;
  localparam int B_STOPEN = 4;
  localparam int B_THR_LO = 8;
  localparam int B_THR_HI = B_THR_LO + THR_W - 1;

  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic             stopen;
    logic             flag;
    logic             ie;
    logic             en;
  } supmon_ctl_t;
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/supmon_pwrup.sv
module supmon_pwrup #(
  parameter int CYCLES = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic ready
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             rdy_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == LAST) rdy_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready = rdy_q & run;

  // Ready can only appear after the comparator was powered in the prior cycle
  assert_rdy_after_run_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> $past(run));
  // Loss of power clears the internal ready state on the next edge
  assert_rdy_cleared_R10: assert property (@(posedge clk) disable iff (rst)
    !run |=> !rdy_q);
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/supmon_regfile.sv
module supmon_regfile
  import supmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             below_s,
  input  logic             ready,
  output supmon_ctl_t      ctl,
  output logic [REG_W-1:0] rdata
);
  supmon_ctl_t ctl_q;
  logic        hw_set;

  assign hw_set = below_s & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else begin
      if (wr) begin
        ctl_q.en     <= wdata[B_EN];
        ctl_q.ie     <= wdata[B_IE];
        ctl_q.stopen <= wdata[B_STOPEN];
        if (!ctl_q.en) ctl_q.thr <= wdata[B_THR_HI:B_THR_LO];
      end
      if (hw_set)  ctl_q.flag <= 1'b1;
      else if (wr) ctl_q.flag <= wdata[B_FLAG];
    end
  end

  assign ctl = ctl_q;

  always_comb begin
    rdata                    = '0;
    rdata[B_EN]              = ctl_q.en;
    rdata[B_RDY]             = ready;
    rdata[B_IE]              = ctl_q.ie;
    rdata[B_FLAG]            = ctl_q.flag;
    rdata[B_STOPEN]          = ctl_q.stopen;
    rdata[B_THR_HI:B_THR_LO] = ctl_q.thr;
  end

  assert_thr_locked_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && ctl_q.en) |=> $stable(ctl_q.thr));
  assert_hw_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    hw_set |=> ctl_q.flag);
  assert_flag_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_q.flag) |-> $past(hw_set || (wr && wdata[B_FLAG])));
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_q.flag) |-> $past(wr && !wdata[B_FLAG]));
endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
  import supmon_pkg::*;
#(
  parameter int PWRUP_CYCLES = 50,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             stop_mode,
  input  logic             below_raw,
  output logic [THR_W-1:0] thr_code,
  output logic             cmp_en,
  output logic             irq
);
  supmon_ctl_t ctl;
  logic        below_s;
  logic        ready;

  supmon_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (below_raw),
    .dout (below_s)
  );

  supmon_pwrup #(.CYCLES(PWRUP_CYCLES)) i_pwrup (
    .clk   (clk),
    .rst   (rst),
    .run   (cmp_en),
    .ready (ready)
  );

  supmon_regfile i_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (bus_wr),
    .wdata   (bus_wdata),
    .below_s (below_s),
    .ready   (ready),
    .ctl     (ctl),
    .rdata   (bus_rdata)
  );

  assign cmp_en   = ctl.en & ~(stop_mode & ~ctl.stopen);
  assign irq      = ctl.flag & ctl.ie;
  assign thr_code = ctl.thr;

  assert_irq_needs_ie_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> bus_rdata[B_IE] && bus_rdata[B_FLAG]);
  assert_ready_needs_cmp_R5: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[B_RDY] |-> cmp_en);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[15:12] == 4'd0 && bus_rdata[7:5] == 3'd0);
endmodule

// File: tb/test_supmon_ctrl.sv
module test_supmon_ctrl;
  localparam int CLK_PER = 10;
  localparam int PWR     = 20;
  localparam int LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        stop_mode = 1'b0;
  logic        below_raw = 1'b0;
  logic [3:0]  thr_code;
  logic        cmp_en;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  supmon_ctrl #(.PWRUP_CYCLES(PWR), .SYNC_STAGES(2)) i_supmon_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .stop_mode(stop_mode), .below_raw(below_raw),
    .thr_code(thr_code), .cmp_en(cmp_en), .irq(irq)
  );

  always #(CLK_PER/2) clk = ~clk;

  // Behavioural reference state
  int m_en, m_ie, m_st, m_flag, m_thr, m_cnt, m_rdy, m_s1, m_s2;

  function automatic int f_cmp();
    return (m_en == 1 && !(stop_mode && m_st == 0)) ? 1 : 0;
  endfunction
  function automatic int f_ready();
    return (m_rdy == 1 && f_cmp() == 1) ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_ie = 0; m_st = 0; m_flag = 0; m_thr = 0;
      m_cnt = 0; m_rdy = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      int cmp, hw, en_old;
      cmp    = f_cmp();
      hw     = (m_s2 == 1 && f_ready() == 1) ? 1 : 0;
      en_old = m_en;
      if (cmp == 0) begin m_cnt = 0; m_rdy = 0; end
      else if (m_rdy == 0) begin
        if (m_cnt == PWR - 1) m_rdy = 1; else m_cnt++;
      end
      m_s2 = m_s1;
      m_s1 = below_raw;
      if (hw == 1) m_flag = 1;
      else if (bus_wr) m_flag = bus_wdata[3];
      if (bus_wr) begin
        m_en = bus_wdata[0]; m_ie = bus_wdata[2]; m_st = bus_wdata[4];
        if (en_old == 0) m_thr = bus_wdata[11:8];
      end
    end
  end

  // Per-cycle comparison a quarter period after each edge
  always @(posedge clk) begin
    #(CLK_PER/4);
    if (!rst && !done) begin
      chk("R1", {bus_rdata[15:12], bus_rdata[7:5]}, 0);
      chk("R3", bus_rdata[11:8], m_thr);
      chk("R3", thr_code, m_thr);
      chk("R4", {bus_rdata[4], bus_rdata[2], bus_rdata[0]}, m_st*4 + m_ie*2 + m_en);
      chk("R5", bus_rdata[1], f_ready());
      chk("R6", cmp_en, f_cmp());
      chk("R7", bus_rdata[3], m_flag);
      chk("R9", irq, m_flag & m_ie);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PER*LIMIT);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    #(CLK_PER/4);
    // R2: reset state
    chk("R2", bus_rdata, 0);
    chk("R2", {thr_code, cmp_en, irq}, 0);

    wr(16'h0500);                       // R3: code written while disabled
    chk("R3", thr_code, 5);
    wr(16'h0905);                       // enable with new code, allowed (enable was 0)
    chk("R3", thr_code, 9);
    wr(16'h0305);                       // R3: locked, code stays 9
    chk("R3", thr_code, 9);
    step(PWR + 2);
    chk("R5", bus_rdata[1], 1);

    below_raw = 1'b1;                   // R7: flag after synchroniser
    step(4);
    chk("R7", bus_rdata[3], 1);
    chk("R9", irq, 1);
    wr(16'h0005);                       // R8: clear while still below
    chk("R8", bus_rdata[3], 1);
    below_raw = 1'b0;
    step(4);
    wr(16'h0005);
    chk("R7", bus_rdata[3], 0);
    wr(16'h000D);                       // R9: software set
    chk("R9", irq, 1);
    wr(16'h0009);                       // ie off: flag kept, irq low
    chk("R9", irq, 0);
    wr(16'h0001);

    @(negedge clk); stop_mode = 1'b1;   // R10: stop without stop monitoring
    #(CLK_PER/4);
    chk("R10", bus_rdata[1], 0);
    chk("R6", cmp_en, 0);
    below_raw = 1'b1;
    step(5);
    chk("R10", bus_rdata[3], 0);
    below_raw = 1'b0;
    step(3);
    stop_mode = 1'b0;
    step(PWR - 2);
    chk("R10", bus_rdata[1], 0);
    step(4);
    chk("R10", bus_rdata[1], 1);

    wr(16'h0011);                       // R10: stop with stop monitoring kept
    stop_mode = 1'b1;
    step(3);
    chk("R10", bus_rdata[1], 1);
    stop_mode = 1'b0;

    wr(16'h0019);                       // set flag, then disable
    wr(16'h0F08);                       // R11: enable off, flag kept
    chk("R11", bus_rdata[1], 0);
    chk("R11", bus_rdata[3], 1);
    chk("R3", thr_code, 9);             // write used enable=1 before it
    wr(16'h0F00);
    chk("R3", thr_code, 15);
    wr(16'h0F01);                       // R11: delay runs again
    step(PWR - 3);
    chk("R11", bus_rdata[1], 0);
    step(4);
    chk("R11", bus_rdata[1], 1);
    step(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule